// File: doc/BRIEF.md
# Flag-and-Enable Interrupt Controller

This block merges four event sources into a single active-low interrupt request. The sources are a watchdog time-out, a periodic tick, a calendar alarm match and a supply-failure warning. Each event pulse sets a sticky flag. The periodic, alarm and supply-failure sources each have an enable bit, so they can drive the interrupt line only when software allows it. The watchdog source has no enable here, because its routing is decided upstream and it always requests an interrupt. The interrupt output is a drive-low enable for an open-drain pad. When the output is 0, the pad floats.

The periodic source is made inside the block. A divider counts ticks of a fast timebase. The timebase ticks at 8192 Hz, so one tick lasts about 122 µs. A 4-bit rate code selects the period, from one tick up to 4096 ticks (500 ms). Rate code 0 turns the periodic source off.

Software clears the flags by reading the flag register. One read clears every flag at once. The clear only takes effect when the address has stayed on the flag register for a minimum number of consecutive clocks, so a passing address glitch cannot wipe pending events. All enables and flags reset to zero at power-up.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `flags_o`, `enables_o` and `irq_drive_low_o` are all 0.
- R2: An event pulse sets its flag on the next clock edge, and the flag stays set until it is cleared. Flag bit positions are: bit 0 watchdog, bit 1 periodic, bit 2 alarm, bit 3 supply-failure. Bits 7:4 read 0.
- R3: `irq_drive_low_o` is 1 exactly when the watchdog flag is set, or when any of the periodic, alarm or supply-failure flags is set together with its enable. A flag whose enable is 0 does not raise the request.
- R4: A write (`wr_i`=1) at address `IEN_ADDR` (default 1) loads the enable register, which appears on `enables_o` after the next edge. The layout is: bits 3:0 rate code, bit 4 periodic enable, bit 5 alarm enable, bit 6 supply-failure enable. Bit 7 reads 0.
- R5: A read (`rd_i`=1) at address `FLAG_ADDR` (default 0) clears all four flags at the edge, and the interrupt line is released. This happens only when, counting that cycle, the address has stayed at `FLAG_ADDR` for at least `HOLD_CYC` (default 5) consecutive cycles.
- R6: A flag read made before the address has been held for `HOLD_CYC` cycles leaves every flag unchanged.
- R7: An event that arrives in the same cycle as a qualified clear leaves its flag set after that edge.
- R8: For rate code c from 3 to 15, the periodic flag sets after 2^(c-3) timebase ticks. Code 1 gives 32 ticks and code 2 gives 64 ticks. Code 0 never sets the periodic flag.
- R9: The periodic flag is set by the divider even when the periodic enable is 0. In that case the interrupt line stays released.
- R10: Any write to the enable register restarts the periodic tick count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tick_i | input | 1 | Fast timebase tick, one cycle wide |
| wdog_evt_i | input | 1 | Watchdog time-out event pulse |
| alarm_evt_i | input | 1 | Alarm match event pulse |
| pfail_evt_i | input | 1 | Supply-failure event pulse |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| flags_o | output | 8 | Flag register readback |
| enables_o | output | 8 | Enable register readback |
| irq_drive_low_o | output | 1 | 1 pulls the interrupt pad low |

## Verification
The assertions make three assumptions about the inputs:
- every event and tick input is a single-cycle pulse sampled at the clock edge;
- `rd_i` and `wr_i` are never both high at the same address;
- the only thing that can make a flag fall is a read strobe at the flag address.

The stimulus drives every input on the falling clock edge and never asserts both strobes in the same cycle. It parks the address on the enable register between accesses, so every flag read starts counting its hold window from zero. The check of coincident events drives the event and the qualifying read in the same cycle on purpose. This matches the rule that a set wins over a clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int RATE_W = 4;
    localparam int PCNT_W = 13;

    typedef struct packed {
        logic pfail;
        logic alarm;
        logic per;
        logic wdog;
    } flag_vec_t;

    typedef struct packed {
        logic              pfail_en;
        logic              alarm_en;
        logic              per_en;
        logic [RATE_W-1:0] rate;
    } ien_reg_t;

    // number of timebase ticks per periodic event; 0 means source off
    function automatic logic [PCNT_W-1:0] period_ticks(input logic [RATE_W-1:0] code);
        logic [PCNT_W-1:0] p;
        case (code)
            4'd0:    p = '0;
            4'd1:    p = PCNT_W'(32);
            4'd2:    p = PCNT_W'(64);
            default: p = PCNT_W'(1) << (code - 4'd3);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/irq_rate_div.sv
module irq_rate_div
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              restart_i,
    output logic              pulse_o
);
    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
        logic              pulse;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [PCNT_W-1:0] period;

    always_comb begin
        period   = period_ticks(rate_i);
        st_d     = st_q;
        st_d.pulse = 1'b0;
        if (restart_i || period == '0) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == period - PCNT_W'(1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/irq_clr_qual.sv
module irq_clr_qual #(
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 0,
    parameter int HOLD_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    output logic              clr_o
);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [HW-1:0] SAT = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [HW-1:0] age;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     at_flag;

    always_comb begin
        at_flag = (addr_i == ADDR_W'(FLAG_ADDR));
        st_d    = st_q;
        if (!at_flag)          st_d.age = '0;
        else if (st_q.age != SAT) st_d.age = st_q.age + HW'(1);
        clr_o = at_flag && rd_i && (st_q.age == SAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t evt_i,
    input  logic      clr_i,
    input  logic      ien_wr_i,
    input  ien_reg_t  ien_wdata_i,
    output flag_vec_t flags_o,
    output ien_reg_t  ien_o,
    output logic      irq_o
);
    typedef struct packed {
        flag_vec_t flags;
        ien_reg_t  ien;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear so no event is lost
        st_d.flags = (clr_i ? flag_vec_t'('0) : st_q.flags) | evt_i;
        if (ien_wr_i) st_d.ien = ien_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign ien_o   = st_q.ien;
    assign irq_o   = st_q.flags.wdog
                   | (st_q.flags.per   & st_q.ien.per_en)
                   | (st_q.flags.alarm & st_q.ien.alarm_en)
                   | (st_q.flags.pfail & st_q.ien.pfail_en);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 0,
    parameter int IEN_ADDR  = 1,
    parameter int HOLD_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wdog_evt_i,
    input  logic              alarm_evt_i,
    input  logic              pfail_evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        flags_o,
    output logic [7:0]        enables_o,
    output logic              irq_drive_low_o
);
    logic      per_pulse, clr, ien_wr;
    flag_vec_t evt, flags;
    ien_reg_t  ien, ien_wdata;

    assign ien_wr    = wr_i && (addr_i == ADDR_W'(IEN_ADDR));
    assign ien_wdata = ien_reg_t'(wdata_i[6:0]);
    assign evt       = '{pfail: pfail_evt_i, alarm: alarm_evt_i,
                         per: per_pulse, wdog: wdog_evt_i};

    irq_rate_div u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .rate_i(ien.rate), .restart_i(ien_wr), .pulse_o(per_pulse)
    );

    irq_clr_qual #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .HOLD_CYC(HOLD_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .clr_o(clr)
    );

    irq_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
        .ien_wr_i(ien_wr), .ien_wdata_i(ien_wdata),
        .flags_o(flags), .ien_o(ien), .irq_o(irq_drive_low_o)
    );

    assign flags_o   = {4'b0000, flags};
    assign enables_o = {1'b0, ien};
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int ADDR_W    = 4,
    parameter int FLAG_ADDR = 0,
    parameter int IEN_ADDR  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdog_evt_i,
    input logic              alarm_evt_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        flags_o,
    input logic [7:0]        enables_o,
    input logic              irq_drive_low_o
);
    // R2
    wdog_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt_i |=> flags_o[0]);
    // R2
    alarm_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[2]) |-> $past(alarm_evt_i));
    // R3
    wdog_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[0] |-> irq_drive_low_o);
    // R3
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[3:0] == 4'b0000) |-> !irq_drive_low_o);
    // R4
    ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(IEN_ADDR)) |=> enables_o == {1'b0, $past(wdata_i[6:0])});
    // R5
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[1]) |-> ($past(rd_i) && $past(addr_i) == ADDR_W'(FLAG_ADDR)));
    // R8
    rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[1]) |-> $past(enables_o[3:0]) != 4'd0);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .IEN_ADDR(IEN_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdog_evt_i(wdog_evt_i), .alarm_evt_i(alarm_evt_i),
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .flags_o(flags_o), .enables_o(enables_o), .irq_drive_low_o(irq_drive_low_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 5;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       tick_i = 0, wdog_evt_i = 0, alarm_evt_i = 0, pfail_evt_i = 0;
    logic [3:0] addr_i = 4'd1;
    logic       rd_i = 0, wr_i = 0;
    logic [7:0] wdata_i = 0;
    logic [7:0] flags_o, enables_o;
    logic       irq_drive_low_o;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdog_evt_i(wdog_evt_i),
        .alarm_evt_i(alarm_evt_i), .pfail_evt_i(pfail_evt_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .flags_o(flags_o),
        .enables_o(enables_o), .irq_drive_low_o(irq_drive_low_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 time unit after the rising edge
    task automatic step();
        @(negedge clk);
    endtask
    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic write_ien(input logic [7:0] d);
        step(); addr_i = 4'd1; wr_i = 1; wdata_i = d;
        settle();
        step(); wr_i = 0;
    endtask

    task automatic read_flags(input int held, input logic evt_wd);
        step(); addr_i = 4'd0;
        for (int i = 1; i < held; i++) begin settle(); step(); end
        rd_i = 1; wdog_evt_i = evt_wd;
        settle();
        step(); rd_i = 0; wdog_evt_i = 0; addr_i = 4'd1;
    endtask

    task automatic pulse_evt(input int which);
        step();
        case (which)
            0: wdog_evt_i = 1;
            1: alarm_evt_i = 1;
            default: pfail_evt_i = 1;
        endcase
        settle();
        step(); wdog_evt_i = 0; alarm_evt_i = 0; pfail_evt_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(); tick_i = 1; settle(); step(); tick_i = 0;
        end
        repeat (3) settle();
    endtask

    task automatic t_reset();
        chk("R1 flags", flags_o, 8'h00);
        chk("R1 enables", enables_o, 8'h00);
        chk("R1 irq", {7'b0, irq_drive_low_o}, 8'h00);
    endtask

    task automatic t_events_and_mask();
        pulse_evt(1); settle();
        chk("R2 alarm flag", flags_o, 8'h04);
        chk("R3 masked alarm", {7'b0, irq_drive_low_o}, 8'h00);
        write_ien(8'h20); settle();
        chk("R4 enable readback", enables_o, 8'h20);
        chk("R3 enabled alarm", {7'b0, irq_drive_low_o}, 8'h01);
        pulse_evt(2); settle();
        chk("R2 pfail flag held", flags_o, 8'h0C);
        read_flags(HOLD, 1'b0);
        chk("R5 cleared", flags_o, 8'h00);
        chk("R5 irq released", {7'b0, irq_drive_low_o}, 8'h00);
        pulse_evt(0); settle();
        chk("R2 wdog flag", flags_o, 8'h01);
        chk("R3 wdog unmasked", {7'b0, irq_drive_low_o}, 8'h01);
    endtask

    task automatic t_hold_and_race();
        read_flags(HOLD - 1, 1'b0);
        chk("R6 short hold keeps", flags_o, 8'h01);
        pulse_evt(1);
        read_flags(HOLD, 1'b1);
        chk("R7 coincident event kept", flags_o, 8'h01);
        read_flags(HOLD + 3, 1'b0);
        chk("R5 long hold clears", flags_o, 8'h00);
    endtask

    task automatic t_periodic(input logic [3:0] code, input int n, input string tag);
        write_ien({4'h0, code});
        ticks(n - 1);
        chk({tag, " before"}, flags_o, 8'h00);
        ticks(1);
        chk({tag, " at period"}, flags_o, 8'h02);
        read_flags(HOLD, 1'b0);
    endtask

    task automatic t_periodic_misc();
        write_ien(8'h00);
        ticks(100);
        chk("R8 code0 off", flags_o, 8'h00);
        write_ien(8'h05);
        ticks(3);
        write_ien(8'h05);
        ticks(3);
        chk("R10 restart", flags_o, 8'h00);
        ticks(1);
        chk("R10 after restart", flags_o, 8'h02);
        chk("R9 polled no irq", {7'b0, irq_drive_low_o}, 8'h00);
        write_ien(8'h15);
        settle();
        chk("R9 enabled irq", {7'b0, irq_drive_low_o}, 8'h01);
        read_flags(HOLD, 1'b0);
        write_ien(8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) settle();
        t_reset();
        t_events_and_mask();
        t_hold_and_race();
        t_periodic(4'd3, 1, "R8 code3");
        t_periodic(4'd5, 4, "R8 code5");
        t_periodic(4'd1, 32, "R8 code1");
        t_periodic(4'd2, 64, "R8 code2");
        t_periodic(4'd15, 4096, "R8 code15");
        t_periodic_misc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule